// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core that runs in one of seven operating modes. Software sees sixteen general registers by index, but the physical storage behind an index depends on the mode held in the current status word. The low eight registers and the program counter are common to every mode. Indices 8 to 12 have a second, private copy that only the fast-interrupt mode uses. The stack pointer and link register (indices 13 and 14) have a private copy in each exception mode, and one copy that user and system mode share.

Next to the general registers, the block keeps the current status word and one saved status word for each of the five exception modes. The current status word can be loaded directly. An exception-entry strobe with a target mode saves the current status word into that mode's saved slot and switches the mode field in the same edge. A separate port reads and writes the saved slot that belongs to the active mode. Decode, pipelining and the choice of which exception to take belong to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cpsr_o` equals 0x00000004 (supervisor), `privileged` is 1, `illegal_mode` is 0, and every saved status slot reads as zero.
- R2: Indices 0 to 7 and index 15 address a single physical copy, whatever the mode.
- R3: Indices 8 to 12 address a private bank in fast-interrupt mode (code 0x08). Every other mode, including an illegal code, uses the shared user copy.
- R4: Indices 13 and 14 have six physical copies: one shared by user (0x01) and system (0x02) mode, and one each for supervisor (0x04), fast interrupt (0x08), interrupt (0x09), abort (0x0A) and undefined (0x0C).
- R5: The active mode is `cpsr_o[4:0]`, with the codes listed in R4. Any other code raises `illegal_mode`, clears `privileged`, and banks as user mode.
- R6: `privileged` is 1 in every legal mode except user, where it is 0.
- R7: When `exc_en` is high and `exc_mode` names an exception mode (0x04, 0x08, 0x09, 0x0A, 0x0C), the next edge stores the old `cpsr_o` in that mode's saved slot and replaces `cpsr_o[4:0]` with `exc_mode`. The upper bits stay unchanged. This overrides `sr_we` in the same cycle. With any other `exc_mode`, the strobe has no effect.
- R8: `ssr_rdata` shows the saved slot of the active mode. In user, system or an illegal mode it reads zero, and `ssr_we` is ignored. If an exception entry targets the slot that `ssr_we` addresses in the same cycle, the entry wins.
- R9: Both read ports are combinational. A read of the index being written in the same cycle returns the old value, and the new value appears after the edge.
- R10: `sr_we` loads `cpsr_o` from `sr_wdata` at the edge. A register write in that same cycle uses the banking of the old mode, and reads use the new banking from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sr_we | input | 1 | Current status load enable |
| sr_wdata | input | 32 | Current status load value |
| cpsr_o | output | 32 | Current status word, low five bits are the mode |
| ssr_we | input | 1 | Saved status write enable for the active mode |
| ssr_wdata | input | 32 | Saved status write value |
| ssr_rdata | output | 32 | Saved status word of the active mode |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Mode entered on the strobe |
| illegal_mode | output | 1 | Active mode code is not one of the seven |
| privileged | output | 1 | Active mode is privileged |

## Verification
Register reads are due in the same cycle the index is presented. Register writes, status loads, saved-slot writes and exception entries become visible only after the next rising edge. The bench changes inputs at the falling edge and samples 1 ns later, which is before that falling edge's own writes can land. One more falling edge has passed before any result that depends on a write is checked. The read-during-write and same-cycle mode-change cases are each sampled on both sides of the edge, so that the old and the new value are both seen.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  localparam int MODE_W         = 5;
  localparam int IDX_W          = 4;
  localparam int NUM_LOW        = 8;   // indices shared by all modes
  localparam int NUM_HI         = 5;   // indices with a fast-interrupt bank
  localparam int NUM_SPLR       = 2;   // stack pointer and link register
  localparam int NUM_SPLR_BANKS = 6;
  localparam int NUM_SAVED      = 5;
  localparam int PHYS_N  = NUM_LOW + 2 * NUM_HI + NUM_SPLR * NUM_SPLR_BANKS + 1;
  localparam int PADDR_W = $clog2(PHYS_N);
  localparam int SLOT_W  = $clog2(NUM_SAVED);
  localparam int SB_W    = $clog2(NUM_SPLR_BANKS);

  typedef enum logic [MODE_W-1:0] {
    MD_USER  = 5'h01,
    MD_SYS   = 5'h02,
    MD_SUP   = 5'h04,
    MD_FAST  = 5'h08,
    MD_IRQ   = 5'h09,
    MD_ABORT = 5'h0A,
    MD_UNDEF = 5'h0C
  } mode_e;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    case (m)
      MD_USER, MD_SYS, MD_SUP, MD_FAST, MD_IRQ, MD_ABORT, MD_UNDEF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_exc_mode(input logic [MODE_W-1:0] m);
    case (m)
      MD_SUP, MD_FAST, MD_IRQ, MD_ABORT, MD_UNDEF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // bank 0 is shared by user, system and illegal codes
  function automatic logic [SB_W-1:0] splr_bank(input logic [MODE_W-1:0] m);
    case (m)
      MD_SUP:   return SB_W'(1);
      MD_FAST:  return SB_W'(2);
      MD_IRQ:   return SB_W'(3);
      MD_ABORT: return SB_W'(4);
      MD_UNDEF: return SB_W'(5);
      default:  return SB_W'(0);
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] saved_slot(input logic [MODE_W-1:0] m);
    case (m)
      MD_FAST:  return SLOT_W'(1);
      MD_IRQ:   return SLOT_W'(2);
      MD_ABORT: return SLOT_W'(3);
      MD_UNDEF: return SLOT_W'(4);
      default:  return SLOT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/bankrf_map.sv
module bankrf_map
  import bankrf_pkg::*;
(
  input  logic [IDX_W-1:0]   idx,
  input  logic [MODE_W-1:0]  mode,
  output logic [PADDR_W-1:0] paddr
);
  localparam logic [IDX_W-1:0]   HI_FIRST   = IDX_W'(NUM_LOW);
  localparam logic [IDX_W-1:0]   SPLR_FIRST = IDX_W'(NUM_LOW + NUM_HI);
  localparam logic [IDX_W-1:0]   PC_IDX     = IDX_W'(NUM_LOW + NUM_HI + NUM_SPLR);
  localparam logic [PADDR_W-1:0] FAST_OFS   = PADDR_W'(NUM_HI);
  localparam logic [PADDR_W-1:0] SPLR_BASE  = PADDR_W'(NUM_LOW + 2 * NUM_HI);
  localparam logic [PADDR_W-1:0] PC_ADDR    = PADDR_W'(PHYS_N - 1);
  localparam logic [PADDR_W-1:0] SPLR_STEP  = PADDR_W'(NUM_SPLR);

  logic fast;
  assign fast = (mode == MD_FAST);

  always_comb begin
    if (idx < HI_FIRST) begin
      paddr = PADDR_W'(idx);
    end else if (idx < SPLR_FIRST) begin
      paddr = PADDR_W'(idx) + (fast ? FAST_OFS : '0);
    end else if (idx == PC_IDX) begin
      paddr = PC_ADDR;
    end else begin
      paddr = SPLR_BASE + SPLR_STEP * PADDR_W'(splr_bank(mode))
            + PADDR_W'(idx - SPLR_FIRST);
    end
  end
endmodule

// File: rtl/bankrf_store.sv
module bankrf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  // one write port, asynchronous reads: fits distributed RAM
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/bankrf_status.sv
module bankrf_status
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sr_we,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              exc_en,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              ssr_we,
  input  logic [DATA_W-1:0] ssr_wdata,
  output logic [DATA_W-1:0] cpsr,
  output logic [DATA_W-1:0] ssr_rdata
);
  localparam logic [DATA_W-1:0] CPSR_RST = {{(DATA_W-MODE_W){1'b0}}, MD_SUP};

  logic [DATA_W-1:0] cpsr_q;
  logic [DATA_W-1:0] saved [NUM_SAVED];
  logic [MODE_W-1:0] cur_mode;
  logic              take_exc;
  logic              cur_has_slot;

  assign cur_mode     = cpsr_q[MODE_W-1:0];
  assign take_exc     = exc_en && is_exc_mode(exc_mode);
  assign cur_has_slot = is_exc_mode(cur_mode);

  always_ff @(posedge clk) begin
    if (rst)           cpsr_q <= CPSR_RST;
    else if (take_exc) cpsr_q <= {cpsr_q[DATA_W-1:MODE_W], exc_mode};
    else if (sr_we)    cpsr_q <= sr_wdata;
  end

  for (genvar k = 0; k < NUM_SAVED; k++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (take_exc && saved_slot(exc_mode) == SLOT_W'(k)) begin
        slot_q <= cpsr_q;
      end else if (ssr_we && cur_has_slot && saved_slot(cur_mode) == SLOT_W'(k)) begin
        slot_q <= ssr_wdata;
      end
    end
    assign saved[k] = slot_q;
  end

  assign cpsr      = cpsr_q;
  assign ssr_rdata = cur_has_slot ? saved[saved_slot(cur_mode)] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_we,
  input  logic [DATA_W-1:0] sr_wdata,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              ssr_we,
  input  logic [DATA_W-1:0] ssr_wdata,
  output logic [DATA_W-1:0] ssr_rdata,
  input  logic              exc_en,
  input  logic [4:0]        exc_mode,
  output logic              illegal_mode,
  output logic              privileged
);
  localparam int NPORT = 3;  // two reads, one write

  logic [MODE_W-1:0]  cur_mode;
  logic [IDX_W-1:0]   map_idx  [NPORT];
  logic [PADDR_W-1:0] map_addr [NPORT];

  assign cur_mode   = cpsr_o[MODE_W-1:0];
  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bankrf_map u_map (
      .idx   (map_idx[p]),
      .mode  (cur_mode),
      .paddr (map_addr[p])
    );
  end

  bankrf_store #(.DATA_W(DATA_W), .DEPTH(PHYS_N)) u_store (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (map_addr[2]),
    .wdata   (wr_data),
    .raddr_a (map_addr[0]),
    .rdata_a (rd_a_data),
    .raddr_b (map_addr[1]),
    .rdata_b (rd_b_data)
  );

  bankrf_status #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .sr_we     (sr_we),
    .sr_wdata  (sr_wdata),
    .exc_en    (exc_en),
    .exc_mode  (exc_mode),
    .ssr_we    (ssr_we),
    .ssr_wdata (ssr_wdata),
    .cpsr      (cpsr_o),
    .ssr_rdata (ssr_rdata)
  );

  assign illegal_mode = !mode_known(cur_mode);
  assign privileged   = mode_known(cur_mode) && (cur_mode != MD_USER);
endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sr_we,
  input logic [DATA_W-1:0] sr_wdata,
  input logic [DATA_W-1:0] cpsr_o,
  input logic [DATA_W-1:0] ssr_rdata,
  input logic              exc_en,
  input logic [4:0]        exc_mode,
  input logic              illegal_mode,
  input logic              privileged
);
  localparam logic [DATA_W-1:0] RST_VAL = {{(DATA_W-MODE_W){1'b0}}, MD_SUP};

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cpsr_o == RST_VAL && privileged && !illegal_mode && ssr_rdata == '0));

  // R5
  illegal_unpriv_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_mode |-> !privileged);

  // R6
  user_unpriv_chk: assert property (@(posedge clk) disable iff (rst)
    (cpsr_o[MODE_W-1:0] == MD_USER) |-> (!privileged && !illegal_mode));

  // R7
  exc_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_en && is_exc_mode(exc_mode)) |=>
      (cpsr_o[MODE_W-1:0] == $past(exc_mode)
       && cpsr_o[DATA_W-1:MODE_W] == $past(cpsr_o[DATA_W-1:MODE_W])
       && ssr_rdata == $past(cpsr_o)));

  // R7
  exc_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_en && !is_exc_mode(exc_mode) && !sr_we) |=> $stable(cpsr_o));

  // R8
  no_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !is_exc_mode(cpsr_o[MODE_W-1:0]) |-> ssr_rdata == '0);

  // R9
  read_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sr_we && !exc_en) |=>
      ((rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data))));

  // R10
  status_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_we && !exc_en) |=> cpsr_o == $past(sr_wdata));
endmodule

bind banked_regfile bankrf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_a_idx     (rd_a_idx),
  .rd_a_data    (rd_a_data),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .sr_we        (sr_we),
  .sr_wdata     (sr_wdata),
  .cpsr_o       (cpsr_o),
  .ssr_rdata    (ssr_rdata),
  .exc_en       (exc_en),
  .exc_mode     (exc_mode),
  .illegal_mode (illegal_mode),
  .privileged   (privileged)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, cpsr_o, ssr_rdata;
  logic        wr_en = 1'b0, sr_we = 1'b0, ssr_we = 1'b0, exc_en = 1'b0;
  logic [31:0] wr_data = '0, sr_wdata = '0, ssr_wdata = '0;
  logic [4:0]  exc_mode = '0;
  logic        illegal_mode, privileged;

  int n_chk = 0;
  int n_fail = 0;

  // mode codes: 0 user, 1 system, 2 supervisor, 3 fast irq, 4 irq, 5 abort, 6 undefined
  logic [4:0] MC [7] = '{5'h01, 5'h02, 5'h04, 5'h08, 5'h09, 5'h0A, 5'h0C};

  always #10 clk = ~clk;  // 50 MHz

  banked_regfile dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .cpsr_o(cpsr_o),
    .ssr_we(ssr_we), .ssr_wdata(ssr_wdata), .ssr_rdata(ssr_rdata),
    .exc_en(exc_en), .exc_mode(exc_mode),
    .illegal_mode(illegal_mode), .privileged(privileged)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sv(input int owner, input int i);
    return 32'hC0DE_0000 | (32'(owner) << 8) | 32'(i);
  endfunction

  // sweep writes modes 0..6 in order; owner = last mode to write that copy
  function automatic int owner(input int m, input int i);
    if (i < 8 || i == 15) return 6;
    if (i < 13) return (m == 3) ? 3 : 6;
    return (m <= 1) ? 1 : m;
  endfunction

  function automatic string rtag(input int i);
    if (i < 8 || i == 15) return "R2 shared index";
    if (i < 13) return "R3 fast bank index";
    return "R4 sp/lr bank index";
  endfunction

  task automatic set_cpsr(input logic [31:0] v);
    @(negedge clk); sr_we = 1'b1; sr_wdata = v;
    @(negedge clk); sr_we = 1'b0;
  endtask

  task automatic wr_reg(input int i, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'(i); wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_ssr(input logic [31:0] v);
    @(negedge clk); ssr_we = 1'b1; ssr_wdata = v;
    @(negedge clk); ssr_we = 1'b0;
  endtask

  task automatic rd_a(input int i, output logic [31:0] v);
    rd_a_idx = 4'(i); #1; v = rd_a_data;
  endtask

  logic done = 1'b0;

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 cpsr after reset", cpsr_o, 32'h0000_0004);
    chk("R1 privileged after reset", {31'b0, privileged}, 32'd1);
    chk("R1 illegal after reset", {31'b0, illegal_mode}, 32'd0);
    chk("R1 saved status after reset", ssr_rdata, 32'd0);

    // banking sweep: write every index in every mode
    for (int m = 0; m < 7; m++) begin
      set_cpsr({27'b0, MC[m]});
      for (int i = 0; i < 16; i++) wr_reg(i, sv(m, i));
    end
    for (int m = 0; m < 7; m++) begin
      set_cpsr({27'b0, MC[m]});
      // R6 privilege per mode
      chk("R6 privilege", {31'b0, privileged}, (m == 0) ? 32'd0 : 32'd1);
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
        #1;
        chk(rtag(i), rd_a_data, sv(owner(m, i), i));
        chk(rtag(15 - i), rd_b_data, sv(owner(m, 15 - i), 15 - i));
      end
    end

    // R5 illegal code banks as user
    set_cpsr(32'h0000_001F);
    chk("R5 illegal flag", {31'b0, illegal_mode}, 32'd1);
    chk("R5 illegal not privileged", {31'b0, privileged}, 32'd0);
    rd_a(8, v);  chk("R5 illegal r8 uses user copy", v, sv(6, 8));
    rd_a(13, v); chk("R5 illegal r13 uses user copy", v, sv(1, 13));
    chk("R8 illegal saved reads zero", ssr_rdata, 32'd0);
    wr_ssr(32'hBEEF_0001);
    chk("R8 illegal saved write ignored", ssr_rdata, 32'd0);
    set_cpsr(32'h0000_0001);
    wr_ssr(32'hBEEF_0002);
    chk("R8 user saved write ignored", ssr_rdata, 32'd0);
    set_cpsr(32'h0000_0002);
    wr_ssr(32'hBEEF_0003);
    chk("R8 system saved write ignored", ssr_rdata, 32'd0);

    // no slot was touched by the ignored writes
    for (int m = 2; m < 7; m++) begin
      set_cpsr({27'b0, MC[m]});
      chk("R8 exception slot still zero", ssr_rdata, 32'd0);
      wr_ssr(32'h5500_0000 | 32'(m));
    end
    for (int m = 2; m < 7; m++) begin
      set_cpsr({27'b0, MC[m]});
      chk("R8 slot per mode", ssr_rdata, 32'h5500_0000 | 32'(m));
    end

    // R7 exception entry beats a status load
    set_cpsr(32'hF000_0001);
    @(negedge clk);
    exc_en = 1'b1; exc_mode = 5'h0A; sr_we = 1'b1; sr_wdata = 32'h0000_0002;
    @(negedge clk);
    exc_en = 1'b0; sr_we = 1'b0;
    #1;
    chk("R7 entry mode field", cpsr_o, 32'hF000_000A);
    chk("R7 entry saves old status", ssr_rdata, 32'hF000_0001);
    // R7 non-exception target has no effect
    @(negedge clk);
    exc_en = 1'b1; exc_mode = 5'h01;
    @(negedge clk);
    exc_en = 1'b0;
    #1;
    chk("R7 ignored target cpsr", cpsr_o, 32'hF000_000A);
    chk("R7 ignored target saved", ssr_rdata, 32'hF000_0001);

    // R8 entry wins over saved write on the same slot
    set_cpsr(32'h2000_0009);
    @(negedge clk);
    exc_en = 1'b1; exc_mode = 5'h09; ssr_we = 1'b1; ssr_wdata = 32'h1111_1111;
    @(negedge clk);
    exc_en = 1'b0; ssr_we = 1'b0;
    #1;
    chk("R8 entry beats saved write", ssr_rdata, 32'h2000_0009);
    // different slots: saved write to irq, entry into fast irq
    @(negedge clk);
    exc_en = 1'b1; exc_mode = 5'h08; ssr_we = 1'b1; ssr_wdata = 32'h2222_2222;
    @(negedge clk);
    exc_en = 1'b0; ssr_we = 1'b0;
    #1;
    chk("R7 fast entry cpsr", cpsr_o, 32'h2000_0008);
    chk("R7 fast entry saved", ssr_rdata, 32'h2000_0009);
    set_cpsr(32'h0000_0009);
    chk("R8 irq slot took saved write", ssr_rdata, 32'h2222_2222);

    // R9 read during write
    set_cpsr(32'h0000_0004);
    @(negedge clk);
    rd_a_idx = 4'd5; wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'hA5A5_0005;
    #1;
    chk("R9 old value during write", rd_a_data, sv(6, 5));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R9 new value after edge", rd_a_data, 32'hA5A5_0005);

    // R10 status load with a write in the same cycle
    @(negedge clk);
    sr_we = 1'b1; sr_wdata = 32'h0000_0008;
    wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h7777_0009; rd_a_idx = 4'd9;
    #1;
    chk("R10 old banking before edge", rd_a_data, sv(6, 9));
    @(negedge clk);
    sr_we = 1'b0; wr_en = 1'b0;
    #1;
    chk("R10 cpsr loaded", cpsr_o, 32'h0000_0008);
    chk("R10 new banking after edge", rd_a_data, sv(3, 9));
    set_cpsr(32'h0000_0001);
    rd_a(9, v);
    chk("R10 write used old mode bank", v, 32'h7777_0009);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule